// File: doc/BRIEF.md
# Encoder Position Reset Mask

This block sits next to a quadrature position counter. It filters the counter's reset requests and revolution-step requests. When the position counter wraps in either direction, or when an index active edge arrives, the block opens a suppression window. The window lasts for a programmable number of position-count strobes: 2, 4 or 8, or none at all. While the window is open, both kinds of request are dropped. This keeps a noisy index or a jittering wrap point from resetting the counter again, or from stepping the revolution count twice.

The window closes early in three cases:
- the count direction reverses;
- the position mode field changes;
- the revolution mode field changes.

Masking only applies in revolution modes 00 and 11. In modes 01 and 10 every request passes unchanged. The position mode never affects how masking behaves; only a change of it matters. The decoder, the counters and any register access sit outside this block.

Top module: `enc_reset_mask`

## Requirements
- R1: The window length comes from `mask_sel_i`: 00 gives no window, 01 gives 2 strobes, 10 gives 4 strobes and 11 gives 8 strobes. After the arming cycle, requests are blocked through the cycle of the last counted strobe and pass from the next cycle on.
- R2: A `wrap_i` pulse or an `index_i` pulse (re)loads the full window length. The window state is registered, so requests in the arming cycle itself are not blocked by that arming.
- R3: While the window is open, `rst_req_o` and `rev_step_o` are both 0. While it is closed, they equal `rst_req_i` and `rev_step_i`. An output is never 1 without its input being 1.
- R4: A strobe whose direction (`step_dir_i`, 1 = down) differs from the previous strobe's direction closes the window from the next cycle. The first strobe after reset, and the first strobe after position mode 00, is never a reversal.
- R5: A change of `pos_mode_i` or `rev_mode_i` from its value in the previous cycle closes the window from the next cycle.
- R6: With `rev_mode_i` at 01 or 10, both outputs follow their inputs in the same cycle, whatever the window state.
- R7: When an arming pulse and a reversal (or a mode change) arrive in the same cycle, the window is reloaded, not closed.
- R8: After reset the window is closed and both requests pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Position-count strobe |
| step_dir_i | input | 1 | Strobe direction, 0 = up, 1 = down |
| wrap_i | input | 1 | Position overflow or underflow pulse |
| index_i | input | 1 | Index active-edge pulse |
| mask_sel_i | input | 2 | Window length select |
| pos_mode_i | input | 2 | Position counter mode field |
| rev_mode_i | input | 2 | Revolution counter mode field |
| rst_req_i | input | 1 | Raw position-counter reset request |
| rev_step_i | input | 1 | Raw revolution-counter step request |
| rst_req_o | output | 1 | Gated position-counter reset request |
| rev_step_o | output | 1 | Gated revolution-counter step request |

## Verification
Directed sequences arm the window at each length and count strobes in one direction. They show exactly where blocking ends, which tells an off-by-one in the counter apart from a wrong decode of the length select. Further sequences insert a direction reversal, a mode-field change, an arming pulse on the same cycle as a reversal, and the unmasked revolution modes. These separate the release causes from each other and from arm priority. A long random run then mixes sparse wrap and index pulses, occasional direction flips and mode changes with dense request traffic. An independent cycle model in the bench scores every cycle of that run.

// File: rtl/enc_mask_pkg.sv
package enc_mask_pkg;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned BASE_LEN = 2;
  localparam int unsigned MAX_LEN  = BASE_LEN << ((1 << SEL_W) - 2);
  localparam int unsigned CNT_W    = $clog2(MAX_LEN) + 1;

  typedef enum logic [MODE_W-1:0] {
    REV_MODE_A = 2'b00,
    REV_MODE_B = 2'b01,
    REV_MODE_C = 2'b10,
    REV_MODE_D = 2'b11
  } rev_mode_e;

  // 0 -> no window, n -> BASE_LEN << (n-1)
  function automatic logic [CNT_W-1:0] win_len(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] len;
    if (sel == '0) len = '0;
    else           len = CNT_W'(BASE_LEN << (sel - 1'b1));
    return len;
  endfunction

  function automatic logic mask_allowed(input logic [MODE_W-1:0] rm);
    return (rm == REV_MODE_A) || (rm == REV_MODE_D);
  endfunction
endpackage

// File: rtl/enc_mask_dir_track.sv
module enc_mask_dir_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic step_dir_i,
  input  logic pos_en_i,
  output logic reversal_o,
  output logic last_dir_o,
  output logic dir_valid_o
);
  logic last_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (!pos_en_i) begin
      valid_q <= 1'b0; // direction unknown while counter disabled
    end else if (step_i) begin
      last_q  <= step_dir_i;
      valid_q <= 1'b1;
    end
  end

  assign reversal_o  = step_i && valid_q && (step_dir_i != last_q);
  assign last_dir_o  = last_q;
  assign dir_valid_o = valid_q;
endmodule

// File: rtl/enc_mask_mode_watch.sv
module enc_mask_mode_watch #(
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] pos_mode_i,
  input  logic [MODE_W-1:0] rev_mode_i,
  output logic              changed_o
);
  logic [MODE_W-1:0] pos_q, rev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      rev_q <= '0;
    end else begin
      pos_q <= pos_mode_i;
      rev_q <= rev_mode_i;
    end
  end

  assign changed_o = (pos_q != pos_mode_i) || (rev_q != rev_mode_i);
endmodule

// File: rtl/enc_mask_window.sv
module enc_mask_window
  import enc_mask_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             release_i,
  input  logic             step_i,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (arm_i)                          cnt_d = win_len(sel_i); // arm wins
    else if (release_i)                 cnt_d = '0;
    else if (step_i && cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/enc_reset_mask.sv
module enc_reset_mask
  import enc_mask_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              step_dir_i,
  input  logic              wrap_i,
  input  logic              index_i,
  input  logic [SEL_W-1:0]  mask_sel_i,
  input  logic [MODE_W-1:0] pos_mode_i,
  input  logic [MODE_W-1:0] rev_mode_i,
  input  logic              rst_req_i,
  input  logic              rev_step_i,
  output logic              rst_req_o,
  output logic              rev_step_o
);
  logic reversal, last_dir, dir_valid, mode_chg, win_active, block;

  enc_mask_dir_track u_dir (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step_i),
    .step_dir_i  (step_dir_i),
    .pos_en_i    (pos_mode_i != '0),
    .reversal_o  (reversal),
    .last_dir_o  (last_dir),
    .dir_valid_o (dir_valid)
  );

  enc_mask_mode_watch #(.MODE_W(MODE_W)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pos_mode_i (pos_mode_i),
    .rev_mode_i (rev_mode_i),
    .changed_o  (mode_chg)
  );

  enc_mask_window u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (wrap_i || index_i),
    .sel_i     (mask_sel_i),
    .release_i (reversal || mode_chg),
    .step_i    (step_i),
    .active_o  (win_active)
  );

  assign block      = win_active && mask_allowed(rev_mode_i);
  assign rst_req_o  = rst_req_i  && !block;
  assign rev_step_o = rev_step_i && !block;
endmodule

// File: rtl/enc_reset_mask_chk.sv
module enc_reset_mask_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       step_i,
  input logic       step_dir_i,
  input logic       wrap_i,
  input logic       index_i,
  input logic [1:0] mask_sel_i,
  input logic [1:0] pos_mode_i,
  input logic [1:0] rev_mode_i,
  input logic       rst_req_i,
  input logic       rev_step_i,
  input logic       rst_req_o,
  input logic       rev_step_o,
  input logic       last_dir,
  input logic       dir_valid
);
  AST_RST_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rst_req_i); // R3
  AST_REV_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_step_o |-> rev_step_i); // R3
  AST_OPEN_MODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rev_mode_i == 2'b01 || rev_mode_i == 2'b10) |->
      (rst_req_o == rst_req_i && rev_step_o == rev_step_i)); // R6
  AST_MODE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pos_mode_i != $past(pos_mode_i) || rev_mode_i != $past(rev_mode_i)) && !wrap_i && !index_i)
      |=> (rst_req_o == rst_req_i && rev_step_o == rev_step_i)); // R5
  AST_REVERSAL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dir_valid && step_dir_i != last_dir && !wrap_i && !index_i)
      |=> (rst_req_o == rst_req_i)); // R4
  AST_ARM_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wrap_i || index_i) && mask_sel_i != 2'b00)
      |=> (rev_mode_i == 2'b01 || rev_mode_i == 2'b10 || !rst_req_o)); // R2
  AST_ARM_OVER_REVERSAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wrap_i || index_i) && mask_sel_i != 2'b00 && step_i && dir_valid && step_dir_i != last_dir)
      |=> (rev_mode_i == 2'b01 || rev_mode_i == 2'b10 || !rev_step_o)); // R7
endmodule

bind enc_reset_mask enc_reset_mask_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .step_i     (step_i),
  .step_dir_i (step_dir_i),
  .wrap_i     (wrap_i),
  .index_i    (index_i),
  .mask_sel_i (mask_sel_i),
  .pos_mode_i (pos_mode_i),
  .rev_mode_i (rev_mode_i),
  .rst_req_i  (rst_req_i),
  .rev_step_i (rev_step_i),
  .rst_req_o  (rst_req_o),
  .rev_step_o (rev_step_o),
  .last_dir   (last_dir),
  .dir_valid  (dir_valid)
);

// File: tb/enc_reset_mask_test.sv
`timescale 1ns/1ps
module enc_reset_mask_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic step_i = 0, step_dir_i = 0, wrap_i = 0, index_i = 0;
  logic [1:0] mask_sel_i = 0, pos_mode_i = 0, rev_mode_i = 0;
  logic rst_req_i = 0, rev_step_i = 0;
  logic rst_req_o, rev_step_o;

  // staged stimulus
  logic s_step = 0, s_dir = 0, s_wrap = 0, s_idx = 0, s_rreq = 0, s_rstep = 0;
  logic [1:0] s_sel = 0, s_pm = 0, s_rm = 0;

  int checks = 0, errors = 0;
  logic obs_rst, obs_rev;

  // bench model
  int   m_cnt = 0;
  logic m_dir = 0, m_valid = 0;
  logic [1:0] m_pm = 0, m_rm = 0;

  always #2 clk_i = ~clk_i;

  enc_reset_mask uut (.*);

  function automatic int len_of(logic [1:0] s);
    return (s == 2'b00) ? 0 : (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 8;
  endfunction

  function automatic logic blocked(int cnt, logic [1:0] rm);
    return (cnt != 0) && (rm == 2'b00 || rm == 2'b11);
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    logic e_rst, e_rev;
    @(negedge clk_i);
    step_i = s_step; step_dir_i = s_dir; wrap_i = s_wrap; index_i = s_idx;
    mask_sel_i = s_sel; pos_mode_i = s_pm; rev_mode_i = s_rm;
    rst_req_i = s_rreq; rev_step_i = s_rstep;
    #1;
    e_rst = s_rreq  && !blocked(m_cnt, s_rm);
    e_rev = s_rstep && !blocked(m_cnt, s_rm);
    obs_rst = rst_req_o; obs_rev = rev_step_o;
    chk({tag, " rst_req"}, rst_req_o, e_rst);
    chk({tag, " rev_step"}, rev_step_o, e_rev);
    @(posedge clk_i);
    if (s_wrap || s_idx)                                  m_cnt = len_of(s_sel);
    else if (s_pm != m_pm || s_rm != m_rm)                m_cnt = 0;
    else if (s_step && m_cnt != 0 && m_valid && s_dir != m_dir) m_cnt = 0;
    else if (s_step && m_cnt != 0)                        m_cnt = m_cnt - 1;
    if (s_pm == 2'b00) m_valid = 0;
    else if (s_step) begin m_valid = 1; m_dir = s_dir; end
    m_pm = s_pm; m_rm = s_rm;
  endtask

  task automatic idle_pulse_clear();
    s_wrap = 0; s_idx = 0; s_step = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R8: idle after reset
    s_rreq = 1; s_rstep = 1;
    tick("R8");
    chk("R8 literal", obs_rst, 1'b1);

    s_pm = 2'b01; s_rm = 2'b00;
    tick("R5"); tick("R5");

    // R1: each length, up strobes
    for (int sel = 1; sel < 4; sel++) begin
      s_sel = 2'(sel);
      s_wrap = 1; tick("R2");
      chk("R2 arm cycle passes", obs_rst, 1'b1);
      s_wrap = 0; s_step = 1; s_dir = 0;
      for (int k = 0; k < len_of(2'(sel)); k++) begin
        tick("R1");
        chk("R1 blocked in window", obs_rst, 1'b0);
      end
      s_step = 0; tick("R1");
      chk("R1 passes after window", obs_rst, 1'b1);
    end

    // R1: sel 00 gives no window
    s_sel = 2'b00; s_idx = 1; tick("R1"); s_idx = 0; tick("R1");
    chk("R1 no window", obs_rev, 1'b1);

    // R4: reversal releases
    s_sel = 2'b11; s_idx = 1; tick("R2"); s_idx = 0;
    s_step = 1; s_dir = 0; tick("R4");
    s_dir = 1; tick("R4"); chk("R4 reversal cycle still blocked", obs_rst, 1'b0);
    s_step = 0; tick("R4"); chk("R4 released", obs_rst, 1'b1);

    // R5: mode change releases
    s_wrap = 1; tick("R2"); s_wrap = 0;
    tick("R3"); chk("R3 rev blocked", obs_rev, 1'b0);
    s_pm = 2'b10; tick("R5"); tick("R5");
    chk("R5 released", obs_rst, 1'b1);
    s_wrap = 1; tick("R2"); s_wrap = 0;
    s_rm = 2'b11; tick("R5"); tick("R5");
    chk("R5 rev mode change released", obs_rev, 1'b1);

    // R7: arm with reversal re-arms
    s_sel = 2'b01; s_wrap = 1; tick("R7"); s_wrap = 0;
    s_step = 1; s_dir = 0; tick("R7");
    s_dir = 1; s_wrap = 1; tick("R7"); s_wrap = 0; s_step = 0;
    tick("R7"); chk("R7 still blocked", obs_rst, 1'b0);

    // R6: open revolution modes
    s_sel = 2'b11; s_idx = 1; tick("R6"); s_idx = 0;
    s_rm = 2'b01; tick("R6"); chk("R6 mode 01 passes", obs_rst, 1'b1);
    s_idx = 1; tick("R6"); s_idx = 0;
    s_rm = 2'b10; tick("R6"); chk("R6 mode 10 passes", obs_rev, 1'b1);

    // random mix scored by the model (R3)
    for (int n = 0; n < 4000; n++) begin
      s_step  = ($urandom % 2) == 0;
      if (($urandom % 8) == 0) s_dir = ~s_dir;
      s_wrap  = ($urandom % 10) == 0;
      s_idx   = ($urandom % 15) == 0;
      if (($urandom % 20) == 0) s_sel = 2'($urandom % 4);
      if (($urandom % 60) == 0) s_pm  = 2'($urandom % 4);
      if (($urandom % 60) == 0) s_rm  = 2'($urandom % 4);
      s_rreq  = ($urandom % 3) != 0;
      s_rstep = ($urandom % 3) != 0;
      tick("R3");
    end
    idle_pulse_clear();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule